// File: doc/BRIEF.md
# Serial Boot Command Sequencer

This block starts a host processor over a two-wire serial link made of a clock line and a data line, with two more side lines: a link enable and a route select. One start pulse makes it play a fixed script. First a setup interval. Then a long idle stretch and a preamble that flushes the target's receive pipes. Then five 72-bit command frames, each followed by an idle stretch except the last. Then a handover tail, in which the clock is parked low and the enable is dropped so that the target can switch its clock source.

The frames are constants fixed at elaboration. A two-bit side code, captured with the start request, chooses which of two boot-image frames goes out in the fourth slot. A code that names neither image aborts the script just before that frame and raises an error flag. In debug mode no frames are sent: the enable line is raised with the route select low, so that an external debugger can own the link.

The serial clock comes from the system clock. Each half of a serial period lasts a parameterised number of system clocks.

Top module: `boot_link_sequencer`

## Requirements
- R1: One serial bit takes 2*HALF_CLKS system clocks: HALF_CLKS with sclk_o low, then HALF_CLKS with sclk_o high. sdata_o changes only while sclk_o is low and is held across the rising edge. Frame bit FRAME_BITS-1 is sent first and bit 0 last.
- R2: In the clock after an accepted non-debug start, the block enters setup for one serial period. During setup sclk_o=1, sdata_o=0, and link_en_o, route_sel_o and aux_en_o are all 1.
- R3: After setup comes the idle stretch: STANDBY_CYC serial cycles with data 1. Then the flush: FLUSH_LO_CYC cycles with data 0, followed by FLUSH_HI_CYC cycles with data 1.
- R4: The frames go out in this order: attention 0, attention 1, attention 2, side frame, go frame. Each frame except the go frame is followed by STANDBY_CYC serial cycles with data 1. While busy, link_en_o, route_sel_o and aux_en_o stay 1 up to the tail.
- R5: side_i is captured when start is accepted. Code 2'b01 selects the primary frame and 2'b10 selects the golden frame.
- R6: Codes 2'b00 and 2'b11 end the run after the idle stretch that follows attention 2. The side frame and the go frame are not sent. All link outputs return to 0, err_o goes to 1 and stays there until the next accepted start, and done_o pulses.
- R7: After the go frame comes the tail, in this order. First, TAIL_HI_CYC serial cycles with data 1. Then one serial period with sclk_o=0 and link_en_o=0. Then TAIL_CLK_CYC serial cycles with link_en_o=0 and data 1. After that sclk_o rests at 0.
- R8: A start with debug_i=1 sends nothing and busy_o stays low. link_en_o goes to 1 while sclk_o, sdata_o, route_sel_o and aux_en_o stay 0. link_en_o stays 1 until the next accepted non-debug start.
- R9: busy_o is 1 from the clock after an accepted start through the last tail cycle. done_o is a one-clock pulse in the clock where busy_o falls, and it also pulses for a debug start.
- R10: start_i, debug_i and side_i have no effect while busy_o is 1.
- R11: In reset and after it, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only while idle |
| debug_i | input | 1 | With start: hand the link to a debugger instead of booting |
| side_i | input | 2 | Boot image code: 01 primary, 10 golden, other codes invalid |
| sclk_o | output | 1 | Serial clock line |
| sdata_o | output | 1 | Serial data line |
| link_en_o | output | 1 | Link enable line |
| route_sel_o | output | 1 | Route select line (1 = sequencer owns the link) |
| aux_en_o | output | 1 | Auxiliary data-path enable |
| busy_o | output | 1 | Script in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 1 | Sticky invalid-side flag |

## Verification
The bench builds the block with HALF_CLKS=3, STANDBY_CYC=12, FLUSH_LO_CYC=5 and FLUSH_HI_CYC=4. It also uses frame constants different from the defaults. These values keep the full 72-bit frames and the 16-cycle tail, so a complete script is about 2,700 clocks. That makes room for primary and golden runs, both invalid codes, a debug hand-off and a start request issued mid-run. An odd half-period shows that each low and high phase lasts exactly HALF_CLKS clocks and is not rounded.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STBY_INIT,
    PH_FLUSH_LO,
    PH_FLUSH_HI,
    PH_FRAME,
    PH_STBY,
    PH_TAIL_HI,
    PH_HANDOVER,
    PH_TAIL_CLK
  } phase_e;

  localparam logic [1:0] SIDE_PRIMARY = 2'b01;
  localparam logic [1:0] SIDE_GOLDEN  = 2'b10;

  // frame slot order: 0..2 attention, 3 side, 4 go
  localparam logic [2:0] SLOT_LAST_ATTN = 3'd2;
  localparam logic [2:0] SLOT_SIDE      = 3'd3;
  localparam logic [2:0] SLOT_GO        = 3'd4;

endpackage

// File: rtl/bsq_half_timer.sv
`timescale 1ns/1ps
module bsq_half_timer #(
  parameter int unsigned HALF_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic half_end_o,
  output logic hi_o
);

  localparam int unsigned W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [W-1:0] LAST = W'(HALF_CLKS - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         hi_q, hi_d;
  logic         at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    hi_d  = hi_q;
    if (!run_i) begin
      cnt_d = '0;
      hi_d  = 1'b0;
    end else if (at_last) begin
      cnt_d = '0;
      hi_d  = ~hi_q;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      hi_q  <= hi_d;
    end
  end

  assign half_end_o = run_i && at_last;
  assign hi_o       = hi_q;

endmodule

// File: rtl/bsq_frame_rom.sv
`timescale 1ns/1ps
module bsq_frame_rom #(
  parameter int unsigned FRAME_BITS = 72,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN0 = '0,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN1 = '0,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN2 = '0,
  parameter logic [FRAME_BITS-1:0] FRM_PRI   = '0,
  parameter logic [FRAME_BITS-1:0] FRM_GLD   = '0,
  parameter logic [FRAME_BITS-1:0] FRM_GO    = '0,
  localparam int unsigned PW = $clog2(FRAME_BITS)
) (
  input  logic [2:0]    slot_i,
  input  logic          golden_i,
  input  logic [PW-1:0] pos_i,
  output logic          bit_o
);

  localparam logic [PW-1:0] TOP_POS = PW'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] frm;

  always_comb begin
    unique case (slot_i)
      3'd0:    frm = FRM_ATTN0;
      3'd1:    frm = FRM_ATTN1;
      3'd2:    frm = FRM_ATTN2;
      3'd3:    frm = golden_i ? FRM_GLD : FRM_PRI;
      default: frm = FRM_GO;
    endcase
  end

  // position 0 is the first bit on the wire: the MSB
  assign bit_o = frm[TOP_POS - pos_i];

endmodule

// File: rtl/boot_link_sequencer.sv
`timescale 1ns/1ps
module boot_link_sequencer
  import boot_seq_pkg::*;
#(
  parameter int unsigned HALF_CLKS    = 4,
  parameter int unsigned STANDBY_CYC  = 5000,
  parameter int unsigned FLUSH_LO_CYC = 256,
  parameter int unsigned FLUSH_HI_CYC = 50,
  parameter int unsigned TAIL_HI_CYC  = 2,
  parameter int unsigned TAIL_CLK_CYC = 16,
  parameter int unsigned FRAME_BITS   = 72,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN0 = 72'h0F_1E2D_3C4B_5A69_7887,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN1 = 72'hC3_A55A_0FF0_3CC3_9669,
  parameter logic [FRAME_BITS-1:0] FRM_ATTN2 = 72'h81_7E18_E724_DB42_BD66,
  parameter logic [FRAME_BITS-1:0] FRM_PRI   = 72'h3A_C5F0_0F96_6912_EDB7,
  parameter logic [FRAME_BITS-1:0] FRM_GLD   = 72'h5C_A3E1_1E78_87B4_4B2D,
  parameter logic [FRAME_BITS-1:0] FRM_GO    = 72'hE4_1B72_8DC6_39A5_5A0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       debug_i,
  input  logic [1:0] side_i,
  output logic       sclk_o,
  output logic       sdata_o,
  output logic       link_en_o,
  output logic       route_sel_o,
  output logic       aux_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       err_o
);

  localparam int unsigned L1 = (STANDBY_CYC > FRAME_BITS) ? STANDBY_CYC : FRAME_BITS;
  localparam int unsigned L2 = (L1 > FLUSH_LO_CYC) ? L1 : FLUSH_LO_CYC;
  localparam int unsigned L3 = (L2 > FLUSH_HI_CYC) ? L2 : FLUSH_HI_CYC;
  localparam int unsigned L4 = (L3 > TAIL_CLK_CYC) ? L3 : TAIL_CLK_CYC;
  localparam int unsigned MAX_LEN = (L4 > TAIL_HI_CYC) ? L4 : TAIL_HI_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);
  localparam int unsigned PW = $clog2(FRAME_BITS);

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cyc_q, cyc_d;
  logic [2:0]       slot_q, slot_d;
  logic [1:0]       side_q, side_d;
  logic             err_q, err_d;
  logic             dbg_q, dbg_d;
  logic             done_q, done_d;

  logic             half_end, hi, cycle_end, seg_last, side_ok, frame_bit;
  logic [CNT_W-1:0] seg_len;

  bsq_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ph_q != PH_IDLE),
    .half_end_o(half_end),
    .hi_o      (hi)
  );

  bsq_frame_rom #(
    .FRAME_BITS(FRAME_BITS),
    .FRM_ATTN0(FRM_ATTN0), .FRM_ATTN1(FRM_ATTN1), .FRM_ATTN2(FRM_ATTN2),
    .FRM_PRI(FRM_PRI), .FRM_GLD(FRM_GLD), .FRM_GO(FRM_GO)
  ) u_rom (
    .slot_i  (slot_q),
    .golden_i(side_q == SIDE_GOLDEN),
    .pos_i   (cyc_q[PW-1:0]),
    .bit_o   (frame_bit)
  );

  assign cycle_end = half_end && hi;
  assign side_ok   = (side_q == SIDE_PRIMARY) || (side_q == SIDE_GOLDEN);

  always_comb begin
    unique case (ph_q)
      PH_STBY_INIT, PH_STBY: seg_len = CNT_W'(STANDBY_CYC);
      PH_FLUSH_LO:           seg_len = CNT_W'(FLUSH_LO_CYC);
      PH_FLUSH_HI:           seg_len = CNT_W'(FLUSH_HI_CYC);
      PH_FRAME:              seg_len = CNT_W'(FRAME_BITS);
      PH_TAIL_HI:            seg_len = CNT_W'(TAIL_HI_CYC);
      PH_TAIL_CLK:           seg_len = CNT_W'(TAIL_CLK_CYC);
      default:               seg_len = CNT_W'(1);
    endcase
  end

  assign seg_last = cycle_end && (cyc_q == seg_len - CNT_W'(1));

  // next-state logic
  always_comb begin
    ph_d   = ph_q;
    cyc_d  = cyc_q;
    slot_d = slot_q;
    side_d = side_q;
    err_d  = err_q;
    dbg_d  = dbg_q;
    done_d = 1'b0;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        err_d  = 1'b0;
        done_d = debug_i;
        dbg_d  = debug_i;
        if (!debug_i) begin
          side_d = side_i;
          ph_d   = PH_SETUP;
          cyc_d  = '0;
          slot_d = '0;
        end
      end
    end else if (seg_last) begin
      cyc_d = '0;
      unique case (ph_q)
        PH_SETUP:     ph_d = PH_STBY_INIT;
        PH_STBY_INIT: ph_d = PH_FLUSH_LO;
        PH_FLUSH_LO:  ph_d = PH_FLUSH_HI;
        PH_FLUSH_HI:  ph_d = PH_FRAME;
        PH_FRAME:     ph_d = (slot_q == SLOT_GO) ? PH_TAIL_HI : PH_STBY;
        PH_STBY: begin
          if (slot_q == SLOT_LAST_ATTN && !side_ok) begin
            ph_d   = PH_IDLE;
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            ph_d   = PH_FRAME;
            slot_d = slot_q + 3'd1;
          end
        end
        PH_TAIL_HI:   ph_d = PH_HANDOVER;
        PH_HANDOVER:  ph_d = PH_TAIL_CLK;
        default: begin
          ph_d   = PH_IDLE;
          done_d = 1'b1;
        end
      endcase
    end else if (cycle_end) begin
      cyc_d = cyc_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cyc_q  <= '0;
      slot_q <= '0;
      side_q <= '0;
      err_q  <= 1'b0;
      dbg_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cyc_q  <= cyc_d;
      slot_q <= slot_d;
      side_q <= side_d;
      err_q  <= err_d;
      dbg_q  <= dbg_d;
      done_q <= done_d;
    end
  end

  // line decode
  always_comb begin
    sclk_o      = 1'b0;
    sdata_o     = 1'b0;
    link_en_o   = dbg_q;
    route_sel_o = 1'b0;
    aux_en_o    = 1'b0;
    if (ph_q != PH_IDLE) begin
      sclk_o      = hi;
      sdata_o     = 1'b1;
      link_en_o   = 1'b1;
      route_sel_o = 1'b1;
      aux_en_o    = 1'b1;
      unique case (ph_q)
        PH_SETUP: begin
          sclk_o  = 1'b1;
          sdata_o = 1'b0;
        end
        PH_FLUSH_LO: sdata_o = 1'b0;
        PH_FRAME:    sdata_o = frame_bit;
        PH_HANDOVER: begin
          sclk_o    = 1'b0;
          link_en_o = 1'b0;
        end
        PH_TAIL_CLK: link_en_o = 1'b0;
        default: ;
      endcase
    end
  end

  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_RISE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $rose(sclk_o)) |-> $stable(sdata_o)); // R1
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!busy_o && !sclk_o && !sdata_o && !aux_en_o)); // R6
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!sclk_o && !sdata_o && !route_sel_o && !aux_en_o)); // R8
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R9
  AST_SIDE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(side_q)); // R10

endmodule

// File: tb/boot_link_sequencer_test.sv
`timescale 1ns/1ps
module boot_link_sequencer_test;

  localparam int HC = 3;
  localparam int SB = 12;
  localparam int FL = 5;
  localparam int FH = 4;
  localparam int TH = 2;
  localparam int TC = 16;
  localparam int FB = 72;
  localparam logic [71:0] A0 = 72'h96_0123_4567_89AB_CDEF;
  localparam logic [71:0] A1 = 72'h3C_F00F_A5A5_1248_7E81;
  localparam logic [71:0] A2 = 72'hB7_6D5E_C4A3_0291_FFE0;
  localparam logic [71:0] SP = 72'h1F_E00E_D11D_C22C_B33B;
  localparam logic [71:0] SG = 72'hA0_5FA0_6996_C33C_0F0F;
  localparam logic [71:0] GW = 72'h7E_8421_1248_F0F0_55AA;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic debug_i = 1'b0;
  logic [1:0] side_i = 2'b00;
  logic sclk_o, sdata_o, link_en_o, route_sel_o, aux_en_o, busy_o, done_o, err_o;

  boot_link_sequencer #(
    .HALF_CLKS(HC), .STANDBY_CYC(SB), .FLUSH_LO_CYC(FL), .FLUSH_HI_CYC(FH),
    .TAIL_HI_CYC(TH), .TAIL_CLK_CYC(TC), .FRAME_BITS(FB),
    .FRM_ATTN0(A0), .FRM_ATTN1(A1), .FRM_ATTN2(A2),
    .FRM_PRI(SP), .FRM_GLD(SG), .FRM_GO(GW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .debug_i(debug_i), .side_i(side_i),
    .sclk_o(sclk_o), .sdata_o(sdata_o), .link_en_o(link_en_o), .route_sel_o(route_sel_o),
    .aux_en_o(aux_en_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
  );

  always #10 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit m_en = 1'b0;
  bit m_err = 1'b0;

  // vector order: sclk, sdata, en, sel, aux, busy, done, err
  function automatic logic [7:0] pack(bit c, bit d, bit e, bit s, bit a, bit b, bit dn, bit er);
    return {c, d, e, s, a, b, dn, er};
  endfunction

  task automatic put(logic [7:0] v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic put_cycles(int n, bit d, bit en, string t);
    for (int i = 0; i < n; i++) begin
      repeat (HC) put(pack(1'b0, d, en, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), t);
      repeat (HC) put(pack(1'b1, d, en, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), t);
    end
  endtask

  task automatic put_frame(logic [71:0] f, string t);
    for (int b = FB - 1; b >= 0; b--) put_cycles(1, f[b], 1'b1, t);
  endtask

  task automatic plan_run(logic [1:0] sd);
    repeat (2 * HC) put(pack(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), "R2");
    put_cycles(SB, 1'b1, 1'b1, "R3");
    put_cycles(FL, 1'b0, 1'b1, "R3");
    put_cycles(FH, 1'b1, 1'b1, "R3");
    put_frame(A0, "R4");
    put_cycles(SB, 1'b1, 1'b1, "R4");
    put_frame(A1, "R4");
    put_cycles(SB, 1'b1, 1'b1, "R4");
    put_frame(A2, "R4");
    put_cycles(SB, 1'b1, 1'b1, "R4");
    if (sd != 2'b01 && sd != 2'b10) begin
      m_en = 1'b0;
      m_err = 1'b1;
      put(pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1), "R6");
      return;
    end
    put_frame((sd == 2'b01) ? SP : SG, "R5");
    put_cycles(SB, 1'b1, 1'b1, "R4");
    put_frame(GW, "R1");
    put_cycles(TH, 1'b1, 1'b1, "R7");
    repeat (2 * HC) put(pack(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), "R7");
    put_cycles(TC, 1'b1, 1'b0, "R7");
    m_en = 1'b0;
    m_err = 1'b0;
    put(pack(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), "R9");
  endtask

  task automatic step();
    logic [7:0] e;
    logic [7:0] got;
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
    end else begin
      e = pack(1'b0, 1'b0, m_en, 1'b0, 1'b0, 1'b0, 1'b0, m_err);
      t = m_en ? "R8" : (m_err ? "R6" : "R11");
    end
    got = {sclk_o, sdata_o, link_en_o, route_sel_o, aux_en_o, busy_o, done_o, err_o};
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %b (sclk,sdata,en,sel,aux,busy,done,err)",
               t, $time, got, e);
    end
  endtask

  task automatic launch(logic [1:0] sd, bit dbg);
    start_i = 1'b1;
    debug_i = dbg;
    side_i = sd;
    if (dbg) begin
      m_en = 1'b1;
      m_err = 1'b0;
      put(pack(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0), "R8");
    end else begin
      plan_run(sd);
    end
    step();
    start_i = 1'b0;
    debug_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step();
    repeat (3) step();
  endtask

  initial begin
    repeat (4) step();             // R11 reset state
    rst_n = 1'b1;
    repeat (3) step();             // R11 after release
    launch(2'b01, 1'b0);           // R5 primary
    drain();
    launch(2'b10, 1'b0);           // R5 golden
    repeat (500) step();
    start_i = 1'b1;                // R10 debug start while busy must be ignored
    debug_i = 1'b1;
    side_i = 2'b00;
    step();
    start_i = 1'b0;
    debug_i = 1'b0;
    repeat (300) step();
    start_i = 1'b1;                // R10 invalid-side start while busy ignored
    side_i = 2'b11;
    step();
    start_i = 1'b0;
    drain();
    launch(2'b00, 1'b0);           // R6 abort with code 00
    drain();
    launch(2'b11, 1'b0);           // R6 abort with code 11
    drain();
    launch(2'b00, 1'b1);           // R8 debug hand-off
    repeat (10) step();
    launch(2'b01, 1'b0);           // R8 hold released by a normal run
    drain();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual still running, expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule